// File: doc/BRIEF.md
# Modem Line Status Register with Change Latching

This block holds the modem status byte of a 16550-style serial port together with the modem control bits that sit beside it. Four modem input lines arrive asynchronously: clear-to-send, data-set-ready, ring indicator and carrier detect. Each passes through a two-flop synchronizer. The block keeps the synchronized level of each line in the upper nibble of the status byte. In the lower nibble it latches a sticky change flag per line, and these flags stay set until software reads the byte.

The modem control bits (DTR, RTS, OUT1, OUT2, LOOP) are written through a simple strobe. While the loop bit is set, the status byte that software reads is rebuilt from the control bits instead of the input lines, and reading it does not disturb the pending change flags. A single output reports that any change flag is pending. The interrupt logic outside the block qualifies this output with its own enable bit.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags), the control bits read 0x08 (OUT2 set) and the pending output is low.
- R2: Status byte layout outside loopback: bit 7 carrier detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send, bit 3 carrier change, bit 2 ring trailing edge, bit 1 data-set-ready change, bit 0 clear-to-send change.
- R3: A level change on clear-to-send, data-set-ready or carrier detect sets that line's change flag and updates its level bit at the third rising clock edge after the input changes.
- R4: The ring flag (bit 2) is set only when the synchronized ring level goes from 1 to 0; a rising ring level sets no flag.
- R5: Change flags are sticky. A read strobe outside loopback clears bits 3:0 at the next clock edge and leaves bits 7:4 unchanged.
- R6: If a change is detected on the same clock edge that a read clears the flags, the flag for that change is set after the edge.
- R7: With the loop bit set the read value is {OUT2, OUT1, DTR, RTS, 0000} in bits 7:0, with control bits DTR=bit 0, RTS=bit 1, OUT1=bit 2, OUT2=bit 3.
- R8: With the loop bit set, bits 3:0 of the read value are 0 and a read strobe leaves the pending change flags in place.
- R9: The pending output is high exactly when at least one change flag is latched, including while in loopback.
- R10: The control register is 5 bits wide with the loop bit in bit 4, and it is loaded on the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control register write value |
| ctl_q | output | 5 | Current control register |
| stat_rd | input | 1 | Status byte read strobe |
| stat_rdata | output | 8 | Status byte read value |
| chg_pend | output | 1 | Any change flag pending |

## Verification
The hardest case to reach is a line change and a read strobe landing on the same clock edge. The synchronizer delay hides that edge from the ports. The stimulus changes a line, waits exactly one edge, and then holds the read strobe across the edge at which the synchronized level reaches the compare stage. The read must still return the old byte, and the next read must show the new flag. A second hard case is a flag raised while in loopback. The flag is invisible in the read value there, so it is observed through the pending output and again after the loop bit is cleared.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NLINES = 4;
    localparam int CTL_W  = 5;

    // Line index inside the status and change nibbles
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    // Control register bit positions
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;

    localparam logic [NLINES-1:0] LINE_RST = 4'b1011;
    localparam logic [CTL_W-1:0]  CTL_RST  = 5'b01000;

    typedef struct packed {
        logic [NLINES-1:0] lvl;
        logic [NLINES-1:0] chg;
    } msr_state_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_lvl,
    input  logic              clr,
    output msr_state_t        st_q
);
    msr_state_t        st_d;
    logic [NLINES-1:0] hit;

    always_comb begin
        hit          = line_lvl ^ st_q.lvl;
        hit[IDX_RI]  = st_q.lvl[IDX_RI] & ~line_lvl[IDX_RI];
        st_d         = st_q;
        st_d.lvl     = line_lvl;
        if (clr) st_d.chg = '0;
        st_d.chg     = st_d.chg | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: LINE_RST, chg: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_in,
    input  logic             dsr_in,
    input  logic             ri_in,
    input  logic             dcd_in,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             stat_rd,
    output logic [7:0]       stat_rdata,
    output logic             chg_pend
);
    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;
    logic [CTL_W-1:0]  ctl_d;
    logic [CTL_W-1:0]  ctl_r;
    msr_state_t        st;
    logic              loop_on;
    logic              rd_clr;

    always_comb begin
        raw_lines          = '0;
        raw_lines[IDX_CTS] = cts_in;
        raw_lines[IDX_DSR] = dsr_in;
        raw_lines[IDX_RI]  = ri_in;
        raw_lines[IDX_DCD] = dcd_in;
    end

    msr_sync #(.W(NLINES), .STAGES(2), .RST_VAL(LINE_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    always_comb begin
        ctl_d = ctl_r;
        if (ctl_wr) ctl_d = ctl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_r <= CTL_RST;
        else        ctl_r <= ctl_d;
    end

    assign loop_on = ctl_r[CTL_LOOP];
    assign rd_clr  = stat_rd & ~loop_on;

    msr_delta u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_lvl (sync_lines),
        .clr      (rd_clr),
        .st_q     (st)
    );

    always_comb begin
        if (loop_on)
            stat_rdata = {ctl_r[CTL_OUT2], ctl_r[CTL_OUT1],
                          ctl_r[CTL_DTR],  ctl_r[CTL_RTS], 4'h0};
        else
            stat_rdata = {st.lvl, st.chg};
    end

    assign chg_pend = |st.chg;
    assign ctl_q    = ctl_r;
endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] ctl_q,
    input logic       stat_rd,
    input logic [7:0] stat_rdata,
    input logic       chg_pend
);
    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_pend && !stat_rd) |=> chg_pend);

    // R8
    loop_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (stat_rdata[3:0] == 4'h0));

    // R4
    ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[4] && $past(!ctl_q[4]) && $rose(stat_rdata[2])) |-> $fell(stat_rdata[6]));

    // R9
    pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> (chg_pend == (stat_rdata[3:0] != 4'h0)));
endmodule

bind modem_status_reg modem_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_q      (ctl_q),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .chg_pend   (chg_pend)
);

// File: tb/sim_modem_status_reg.sv
`timescale 1ns/1ps
module sim_modem_status_reg;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cts_in = 1, dsr_in = 1, ri_in = 0, dcd_in = 1;
    logic       ctl_wr = 0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_q;
    logic       stat_rd = 0;
    logic [7:0] stat_rdata;
    logic       chg_pend;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    modem_status_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .chg_pend(chg_pend)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // monitor: pops expected read values while the strobe is held
    always @(negedge clk) begin
        if (stat_rd) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 8'h00, 8'hFF);
            end else begin
                check(tag_q.pop_front(), stat_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd(logic [7:0] exp, string req);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        stat_rd = 1;
        @(posedge clk); #1;
        stat_rd = 0;
    endtask

    task automatic wr_ctl(logic [4:0] v);
        @(posedge clk); #1;
        ctl_wr = 1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset values
        check("R1 ctl", {3'b0, ctl_q}, 8'h08);
        check("R1 pend", {7'b0, chg_pend}, 8'h00);
        rd(8'hB0, "R1 status");

        // R3 clear-to-send drop, R2 layout
        cts_in = 0; settle();
        check("R9 pend set", {7'b0, chg_pend}, 8'h01);
        rd(8'hA1, "R3 cts change");
        rd(8'hA0, "R5 cleared");
        @(negedge clk);
        check("R9 pend clear", {7'b0, chg_pend}, 8'h00);

        // R4 ring rise then fall
        ri_in = 1; settle();
        rd(8'hE0, "R4 ring rise no flag");
        ri_in = 0; settle();
        rd(8'hA4, "R4 ring fall flag");
        rd(8'hA0, "R5 ring flag cleared");

        // R2 two lines at once
        dsr_in = 0; dcd_in = 0; settle();
        rd(8'h0A, "R2 dsr+dcd flags");
        rd(8'h00, "R5 levels kept");

        // R6 change and read on the same edge
        #1 cts_in = 1;
        @(posedge clk);
        rd(8'h00, "R6 old value on collision");
        rd(8'h11, "R6 flag survives clear");
        rd(8'h10, "R6 then cleared");

        // R7 / R10 loopback mapping
        wr_ctl(5'h1F);
        @(negedge clk);
        check("R10 ctl load", {3'b0, ctl_q}, 8'h1F);
        rd(8'hF0, "R7 all outputs");
        wr_ctl(5'h11);
        rd(8'h20, "R7 dtr to bit5");
        wr_ctl(5'h12);
        rd(8'h10, "R7 rts to bit4");

        // R8 flag raised in loop survives loop read
        #1 dsr_in = 1; settle();
        check("R9 pend in loop", {7'b0, chg_pend}, 8'h01);
        rd(8'h10, "R8 low nibble zero");
        wr_ctl(5'h00);
        rd(8'h32, "R8 flag kept after loop");
        rd(8'h30, "R5 cleared after loop");

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule